// File: doc/BRIEF.md
# Paged Register Access Sequencer with Recovery Gaps

This block sits between a simple request port and the control and data ports of a two-channel serial controller whose internal registers are reached through a pointer. A caller asks for one logical register operation: a channel, a register number from 0 to 63, the direction, a write value and a flag that drops the closing recovery gap. The block turns that request into the bus strobes the controller needs. It writes the pointer first when one is needed, switches the option bank before it touches register 7 or its alternate, and leaves a fixed number of quiet system cycles between strobes.

The controller cannot report what was written to most of its write registers. The block therefore keeps a copy of every value written, per channel, and answers reads of those registers from the copy without any bus traffic. Register 9 is common to both channels and has a single copy. Reads that only one channel can answer are steered to that channel. Numbers outside the legal sets end the request with an error and no bus activity.

The recovery gap is `GAP_CYC = ceil(3.5 * SYS_KHZ / CTRL_KHZ)` system cycles, with a minimum of 1.

Top module: `ptr_reg_access_seq`

## Requirements
- R1: The legal write numbers are 0 to 15 and 33. The legal read numbers are 1 to 7, 9 to 15, 16, 17, 18, 19, 22, 23, 24, 26 and 33. Any other request ends with `done` and `error` both high, and no bus strobe is issued.
- R2: A write to register 0 is a single control-port write of the value. It changes no stored copy.
- R3: Every other write is two control-port writes: the register number, then the value. Each transaction leaves at least `GAP_CYC` strobe-free cycles between two strobes. The sequencer issues strobes exactly `GAP_CYC+1` cycles apart, and the first strobe comes in the cycle after acceptance.
- R4: `done` rises `GAP_CYC+1` cycles after the last strobe. When the skip flag is set, it rises one cycle after the last strobe.
- R5: Before a write to register 7, if bit 0 of channel's stored register 15 is 1, the sequencer writes 15 and then that copy with bit 0 cleared, and updates the copy. If the bit is 0, no extra writes are made.
- R6: A write to number 33 (alternate register 7) is preceded by the writes 15 and the copy with bit 0 set, but only when the bit is 0. The number 7 is then used as the pointer, and the value is stored in channel's slot 8.
- R7: A read of a stored register returns the copy with `done` in the cycle after acceptance and with no strobe. Number 33 returns slot 8.
- R8: The stored copy of register 9 keeps bits 5:0 and is shared by both channels. The copy of register 14 keeps bits 4:0. The full value still goes on the bus. Writes to register 8 are not stored.
- R9: Reads of number 19 always go to channel 0. Reads of number 18 always go to channel 1.
- R10: Number 16 is read with one control-port read strobe. Number 24 is read with one data-port read strobe. Either read returns the bus data sampled in that strobe cycle.
- R11: Numbers 17, 18, 19, 22, 23 and 26 are read as a control-port write of the number minus 16, a gap, and then a control-port read.
- R12: A request is accepted only while `idle` is high, and a request seen while busy is ignored. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ch | input | 1 | Channel (0 or 1) |
| req_reg | input | 6 | Logical register number |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write value |
| req_nogap | input | 1 | Skip the gap after the last strobe |
| idle | output | 1 | Ready to accept a request |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Illegal number, valid with done |
| rdata | output | 8 | Read result, valid with done |
| bus_wr_stb | output | 1 | Bus write strobe |
| bus_rd_stb | output | 1 | Bus read strobe |
| bus_port | output | 1 | 0 = control port, 1 = data port |
| bus_ch | output | 1 | Channel addressed by the strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, sampled in a read strobe cycle |

## Verification
The bench first sets and clears bit 0 of the stored register 15. It then writes register 7 and number 33 in both bank states. A design that ignored the copy would emit extra bank-switch writes, or miss them, so the strobe sequence would differ. The bench writes register 9 on one channel and reads it back on the other, and it writes unmasked values to registers 9 and 14. A per-channel copy or a missing mask therefore returns the wrong readback. It issues reads 18 and 19 from the wrong channel to catch a missing redirect. It times every strobe and `done` against the gap count, with and without the skip flag, so a gap that is one cycle short is caught. It also pokes a second request while the block is busy, and checks that illegal numbers cause no bus strobe.

// File: rtl/ptr_reg_access_seq.sv
module ptr_reg_access_seq #(
  parameter int SYS_KHZ  = 50000,
  parameter int CTRL_KHZ = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_ch,
  input  logic [5:0] req_reg,
  input  logic       req_wr,
  input  logic [7:0] req_wdata,
  input  logic       req_nogap,
  output logic       idle,
  output logic       done,
  output logic       error,
  output logic [7:0] rdata,
  output logic       bus_wr_stb,
  output logic       bus_rd_stb,
  output logic       bus_port,
  output logic       bus_ch,
  output logic [7:0] bus_wdata,
  input  logic [7:0] bus_rdata
);
  localparam int GAP_RAW = (7 * SYS_KHZ + 2 * CTRL_KHZ - 1) / (2 * CTRL_KHZ);
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CW      = $clog2(GAP_CYC + 2) + 1;
  localparam int MAXA    = 6;
  localparam logic [1:0] K_CW = 2'd0, K_CR = 2'd1, K_DR = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP, S_DONE} st_t;
  st_t st;

  logic [7:0] sh [2][16];
  logic [7:0] sh9;

  logic [1:0] qk [MAXA];
  logic [7:0] qd [MAXA];
  logic       qc [MAXA];
  logic [1:0] nk [MAXA];
  logic [7:0] nd [MAXA];
  logic       nc [MAXA];
  logic [2:0] nn, qn, idx;
  logic [CW-1:0] cnt;
  logic nogap_q, last_q, err_q;

  logic       legal, shd_rd;
  logic [7:0] shd_val;
  logic       sh_we, b15_we, sh9_we;
  logic [3:0] sh_idx;
  logic [7:0] sh_val, b15_val;
  logic       rch;
  logic [7:0] cur15;

  wire accept = req_valid && (st == S_IDLE);
  assign idle = (st == S_IDLE);
  assign done = (st == S_DONE);
  assign error = done && err_q;
  assign cur15 = sh[req_ch][15];

  always_comb begin
    for (int i = 0; i < MAXA; i++) begin
      nk[i] = K_CW; nd[i] = '0; nc[i] = 1'b0;
    end
    nn = '0; legal = 1'b0; shd_rd = 1'b0; shd_val = '0;
    sh_we = 1'b0; sh_idx = '0; sh_val = '0;
    b15_we = 1'b0; b15_val = '0; sh9_we = 1'b0;
    rch = req_ch;
    if (req_wr) begin
      if (req_reg <= 6'd15 || req_reg == 6'd33) begin
        legal = 1'b1;
        if (req_reg == 6'd0) begin
          nk[0] = K_CW; nd[0] = req_wdata; nc[0] = req_ch; nn = 3'd1;
        end else begin
          if (req_reg == 6'd7 && cur15[0]) begin
            b15_we = 1'b1; b15_val = cur15 & 8'hFE;
          end
          if (req_reg == 6'd33 && !cur15[0]) begin
            b15_we = 1'b1; b15_val = cur15 | 8'h01;
          end
          if (b15_we) begin
            nk[nn] = K_CW; nd[nn] = 8'd15;   nc[nn] = req_ch; nn = nn + 3'd1;
            nk[nn] = K_CW; nd[nn] = b15_val; nc[nn] = req_ch; nn = nn + 3'd1;
          end
          nk[nn] = K_CW; nc[nn] = req_ch;
          nd[nn] = (req_reg == 6'd33) ? 8'd7 : {4'd0, req_reg[3:0]};
          nn = nn + 3'd1;
          nk[nn] = K_CW; nd[nn] = req_wdata; nc[nn] = req_ch; nn = nn + 3'd1;
          if (req_reg == 6'd9) sh9_we = 1'b1;
          else if (req_reg == 6'd33) begin
            sh_we = 1'b1; sh_idx = 4'd8; sh_val = req_wdata;
          end else if (req_reg != 6'd8) begin
            sh_we = 1'b1; sh_idx = req_reg[3:0];
            sh_val = (req_reg == 6'd14) ? (req_wdata & 8'h1F) : req_wdata;
          end
        end
      end
    end else begin
      case (req_reg)
        6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7,
        6'd10, 6'd11, 6'd12, 6'd13, 6'd14, 6'd15: begin
          legal = 1'b1; shd_rd = 1'b1; shd_val = sh[req_ch][req_reg[3:0]];
        end
        6'd9:  begin legal = 1'b1; shd_rd = 1'b1; shd_val = sh9; end
        6'd33: begin legal = 1'b1; shd_rd = 1'b1; shd_val = sh[req_ch][8]; end
        6'd16: begin
          legal = 1'b1; nk[0] = K_CR; nc[0] = req_ch; nn = 3'd1;
        end
        6'd24: begin
          legal = 1'b1; nk[0] = K_DR; nc[0] = req_ch; nn = 3'd1;
        end
        6'd17, 6'd18, 6'd19, 6'd22, 6'd23, 6'd26: begin
          legal = 1'b1;
          if (req_reg == 6'd19) rch = 1'b0;
          if (req_reg == 6'd18) rch = 1'b1;
          nk[0] = K_CW; nd[0] = {4'd0, req_reg[3:0]}; nc[0] = rch;
          nk[1] = K_CR; nc[1] = rch; nn = 3'd2;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int r = 0; r < 16; r++) sh[c][r] <= '0;
      sh9 <= '0;
    end else if (accept && legal && req_wr) begin
      if (b15_we) sh[req_ch][15] <= b15_val;
      if (sh_we)  sh[req_ch][sh_idx] <= sh_val;
      if (sh9_we) sh9 <= req_wdata & 8'h3F;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; qn <= '0; cnt <= '0;
      nogap_q <= 1'b0; last_q <= 1'b0; err_q <= 1'b0; rdata <= '0;
      for (int i = 0; i < MAXA; i++) begin
        qk[i] <= K_CW; qd[i] <= '0; qc[i] <= 1'b0;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          err_q <= !legal;
          nogap_q <= req_nogap;
          idx <= '0; qn <= nn;
          for (int i = 0; i < MAXA; i++) begin
            qk[i] <= nk[i]; qd[i] <= nd[i]; qc[i] <= nc[i];
          end
          if (shd_rd) rdata <= shd_val;
          st <= (!legal || shd_rd) ? S_DONE : S_ACC;
        end
        S_ACC: begin
          if (qk[idx] != K_CW) rdata <= bus_rdata;
          last_q <= (idx == qn - 3'd1);
          cnt <= CW'(GAP_CYC - 1);
          if (idx == qn - 3'd1 && nogap_q) st <= S_DONE;
          else st <= S_GAP;
        end
        S_GAP: begin
          if (cnt == '0) begin
            if (last_q) st <= S_DONE;
            else begin st <= S_ACC; idx <= idx + 3'd1; end
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_wr_stb = (st == S_ACC) && (qk[idx] == K_CW);
  assign bus_rd_stb = (st == S_ACC) && (qk[idx] != K_CW);
  assign bus_port   = (st == S_ACC) && (qk[idx] == K_DR);
  assign bus_ch     = (st == S_ACC) && qc[idx];
  assign bus_wdata  = bus_wr_stb ? qd[idx] : 8'd0;

  logic [CW-1:0] since;
  logic seen;
  logic [3:0] txn_cnt;
  logic shd_q;
  wire stb = bus_wr_stb || bus_rd_stb;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0; seen <= 1'b0; txn_cnt <= '0; shd_q <= 1'b0;
    end else if (accept) begin
      since <= '0; seen <= 1'b0; txn_cnt <= '0; shd_q <= shd_rd;
    end else if (stb) begin
      since <= '0; seen <= 1'b1; txn_cnt <= txn_cnt + 4'd1;
    end else if (since != {CW{1'b1}}) begin
      since <= since + 1'b1;
    end
  end

  a_r1_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (txn_cnt == 4'd0 && !stb));
  a_r3_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && seen) |-> (since >= CW'(GAP_CYC)));
  a_r7_shadow_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (done && shd_q) |-> (txn_cnt == 4'd0));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_stb && bus_rd_stb));
  a_r12_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !stb);
endmodule

// File: tb/ptr_reg_access_seq_tb.sv
module ptr_reg_access_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int G = 9;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ch = 0, req_wr = 0, req_nogap = 0;
  logic [5:0] req_reg = '0;
  logic [7:0] req_wdata = '0;
  logic idle, done, error, bus_wr_stb, bus_rd_stb, bus_port, bus_ch;
  logic [7:0] rdata, bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdata = 8'h3C ^ {bus_port, 6'd0, bus_ch};

  ptr_reg_access_seq #(.SYS_KHZ(20000), .CTRL_KHZ(8000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
    .req_reg(req_reg), .req_wr(req_wr), .req_wdata(req_wdata),
    .req_nogap(req_nogap), .idle(idle), .done(done), .error(error),
    .rdata(rdata), .bus_wr_stb(bus_wr_stb), .bus_rd_stb(bus_rd_stb),
    .bus_port(bus_port), .bus_ch(bus_ch), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  logic [27:0] lg [16];
  int lg_n = 0;
  int done_cyc = 0;
  bit done_seen = 0;
  logic done_err;
  logic [7:0] done_rd;

  always @(negedge clk) begin
    if ((bus_wr_stb || bus_rd_stb) && lg_n < 16) begin
      lg[lg_n] <= {16'(cyc), bus_port, bus_wr_stb, bus_ch, 1'b0, bus_wdata};
      lg_n <= lg_n + 1;
    end
    if (done) begin
      done_seen <= 1; done_cyc <= cyc; done_err <= error; done_rd <= rdata;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  logic [7:0] m_sh [2][16];
  logic [7:0] m_sh9;
  logic [11:0] ex [6];
  int ex_n;

  function automatic logic [11:0] acc(input bit port, input bit wr, input bit ch, input logic [7:0] d);
    return {port, wr, ch, 1'b0, d};
  endfunction

  function automatic logic [7:0] bus_val(input bit port, input bit ch);
    return 8'h3C ^ {port, 6'd0, ch};
  endfunction

  task automatic run(input bit ch, input logic [5:0] r, input bit wr,
                     input logic [7:0] v, input bit ng, input bit poke, input string rq);
    bit ex_err = 0, is_rd_bus = 0, shd = 0;
    logic [7:0] ex_rd = '0;
    bit rc;
    int a, last, expd;
    ex_n = 0;
    if (wr) begin
      if (r > 15 && r != 33) ex_err = 1;
      else if (r == 0) begin ex[0] = acc(0,1,ch,v); ex_n = 1; end
      else begin
        if (r == 7 && m_sh[ch][15][0]) begin
          m_sh[ch][15][0] = 0;
          ex[ex_n++] = acc(0,1,ch,8'd15); ex[ex_n++] = acc(0,1,ch,m_sh[ch][15]);
        end
        if (r == 33 && !m_sh[ch][15][0]) begin
          m_sh[ch][15][0] = 1;
          ex[ex_n++] = acc(0,1,ch,8'd15); ex[ex_n++] = acc(0,1,ch,m_sh[ch][15]);
        end
        ex[ex_n++] = acc(0,1,ch,(r == 33) ? 8'd7 : {4'd0, r[3:0]});
        ex[ex_n++] = acc(0,1,ch,v);
        if (r == 9) m_sh9 = v & 8'h3F;
        else if (r == 33) m_sh[ch][8] = v;
        else if (r == 14) m_sh[ch][14] = v & 8'h1F;
        else if (r != 8) m_sh[ch][r[3:0]] = v;
      end
    end else begin
      if ((r >= 1 && r <= 7) || (r >= 10 && r <= 15)) begin shd = 1; ex_rd = m_sh[ch][r[3:0]]; end
      else if (r == 9) begin shd = 1; ex_rd = m_sh9; end
      else if (r == 33) begin shd = 1; ex_rd = m_sh[ch][8]; end
      else if (r == 16) begin ex[0] = acc(0,0,ch,0); ex_n = 1; is_rd_bus = 1; ex_rd = bus_val(0,ch); end
      else if (r == 24) begin ex[0] = acc(1,0,ch,0); ex_n = 1; is_rd_bus = 1; ex_rd = bus_val(1,ch); end
      else if (r==17 || r==18 || r==19 || r==22 || r==23 || r==26) begin
        rc = (r == 19) ? 1'b0 : (r == 18) ? 1'b1 : ch;
        ex[0] = acc(0,1,rc,{4'd0, r[3:0]}); ex[1] = acc(0,0,rc,0); ex_n = 2;
        is_rd_bus = 1; ex_rd = bus_val(0,rc);
      end else ex_err = 1;
    end
    @(negedge clk);
    lg_n = 0; done_seen = 0;
    req_valid = 1; req_ch = ch; req_reg = r; req_wr = wr; req_wdata = v; req_nogap = ng;
    @(negedge clk);
    a = cyc;
    req_valid = 0;
    if (poke) begin
      @(negedge clk);
      req_valid = 1; req_reg = 6'd16; req_wr = 0; req_ch = ~ch;
      @(negedge clk);
      req_valid = 0;
    end
    for (int t = 0; t < 400 && !done_seen; t++) @(negedge clk);
    chk(done_seen, {rq, " done seen"}, done_seen, 1);
    chk(lg_n == ex_n, {rq, " strobe count"}, lg_n, ex_n);
    for (int k = 0; k < ex_n && k < lg_n; k++)
      chk(lg[k] == {16'(a + k*(G+1)), ex[k]}, {rq, " strobe"}, lg[k], {16'(a + k*(G+1)), ex[k]});
    last = a + (ex_n - 1) * (G + 1);
    expd = (ex_n == 0) ? a : (ng ? last + 1 : last + G + 1);
    chk(done_cyc == expd, {rq, " done timing"}, done_cyc, expd);
    chk(done_err == ex_err, {rq, " error"}, done_err, ex_err);
    if (shd || is_rd_bus) chk(done_rd == ex_rd, {rq, " rdata"}, done_rd, ex_rd);
    if (poke) begin
      repeat (2*G + 4) @(negedge clk);
      chk(lg_n == ex_n, "R12 busy request ignored", lg_n, ex_n);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [5:0] pool [24];
    logic [5:0] rr;
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) for (int i = 0; i < 16; i++) m_sh[c][i] = 0;
    m_sh9 = 0;
    pool = '{0,1,2,3,5,7,8,9,12,14,15,16,17,18,19,20,22,23,24,26,33,32,40,63};
    repeat (3) @(negedge clk);
    chk(idle && !done && !error && !bus_wr_stb && !bus_rd_stb, "R12 reset state",
        {idle, done, error}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    run(0, 6'd5, 0, 0, 0, 0, "R7 reset copy");
    run(0, 6'd0, 1, 8'hA5, 0, 0, "R2 reg0 write");
    run(1, 6'd4, 1, 8'h81, 0, 0, "R3 pointer write");
    run(1, 6'd4, 0, 0, 0, 0, "R7 readback");
    run(0, 6'd15, 1, 8'h81, 1, 0, "R4 skip gap");
    run(0, 6'd7, 1, 8'h22, 0, 0, "R5 bank clear");
    run(0, 6'd7, 1, 8'h23, 0, 0, "R5 no bank write");
    run(0, 6'd33, 1, 8'h44, 0, 0, "R6 bank set");
    run(0, 6'd33, 1, 8'h45, 1, 0, "R6 bank kept");
    run(0, 6'd33, 0, 0, 0, 0, "R6 slot8 read");
    run(0, 6'd15, 0, 0, 0, 0, "R5 copy of 15");
    run(1, 6'd9, 1, 8'hFF, 0, 0, "R8 reg9 write");
    run(0, 6'd9, 0, 0, 0, 0, "R8 reg9 shared");
    run(1, 6'd14, 1, 8'hFF, 0, 0, "R8 reg14 write");
    run(1, 6'd14, 0, 0, 0, 0, "R8 reg14 mask");
    run(0, 6'd8, 1, 8'h77, 0, 0, "R8 reg8 unstored");
    run(0, 6'd18, 0, 0, 0, 0, "R9 redirect 18");
    run(1, 6'd19, 0, 0, 0, 0, "R9 redirect 19");
    run(1, 6'd16, 0, 0, 1, 0, "R10 status read");
    run(0, 6'd24, 0, 0, 0, 0, "R10 data read");
    run(1, 6'd26, 0, 0, 0, 0, "R11 two-phase read");
    run(0, 6'd32, 1, 8'h11, 0, 0, "R1 illegal write");
    run(0, 6'd0, 0, 0, 0, 0, "R1 illegal read 0");
    run(1, 6'd20, 0, 0, 0, 0, "R1 illegal read 20");
    run(0, 6'd3, 1, 8'h5A, 0, 1, "R12 poke while busy");
    for (int n = 0; n < 180; n++) begin
      rr = pool[$urandom % 24];
      run($urandom % 2, rr, $urandom % 2, 8'($urandom), $urandom % 2, 0, "R3 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule